// File: doc/BRIEF.md
# Ratio-Changing Lane FIFO

This block is a shallow dual-clock FIFO that sits beside an I/O bank. It carries ten lanes side by side. It can either pass each lane through at its own width or change the lane width between the write side and the read side. A static mode input selects the variant:

- **Pass-through mode:** 4 bits in and 4 bits out per lane.
- **Widening mode:** two successive 4-bit writes are packed into one 8-bit read.
- **Narrowing mode:** one 8-bit write leaves the FIFO as two successive 4-bit reads.

The write and read clocks are unrelated. Pointers cross between them in Gray code through two-flop synchronizers.

Storage is eight entries. Each entry holds one 8-bit slot per lane, so occupancy and all four flags are counted in entries, whatever the mode. Full and almost-full are computed in the write clock domain. Empty and almost-empty are computed in the read clock domain.

An output-disable input drives every read data bit high while read enable is low. This lets the consumer see an idle bus as all ones.

Lane `i` of both data buses occupies bits `[8i+7:8i]`.

Top module: `io_ratio_fifo`

## Requirements
- R1: In pass-through mode (`cfgMode` = 0, and also 3) each accepted write stores bits `[8i+3:8i]` of lane `i`, and bits `[8i+7:8i+4]` are ignored. Each accepted read presents that nibble on `rdData[8i+3:8i]` with `rdData[8i+7:8i+4]` = 0, from the clock edge that accepts the read. Words leave in write order.
- R2: In widening mode (`cfgMode` = 1) two accepted writes form one entry. The first write supplies lane bits `[3:0]` of the read word and the second write supplies bits `[7:4]`. One accepted read presents the full 8-bit lane.
- R3: In narrowing mode (`cfgMode` = 2) each accepted write stores the whole 8-bit lane as one entry. The first accepted read of that entry presents the low nibble and the second presents the high nibble, both in lane bits `[3:0]` with bits `[7:4]` = 0. Only the second read frees the entry.
- R4: `full` rises once 8 entries are held. A write (either half in widening mode) while `full` is high is dropped and changes no state.
- R5: A read while `empty` is high is dropped. `rdData` keeps its last value and the read position does not move.
- R6: `almostFull` is high while the write-side occupancy is at least `DEPTH - AF_GAP` (7 by default). `full` implies `almostFull`.
- R7: `almostEmpty` is high while the read-side occupancy is at most `AE_GAP` (1 by default). It may fall and rise again without `empty` ever rising in between, and `empty` implies `almostEmpty`.
- R8: With `outDisable` high, `rdData` is all ones whenever `rdEn` is low. With `rdEn` high, or with `outDisable` low, `rdData` shows the last word read.
- R9: After reset (`wrRstN` and `rdRstN` low, `cfgMode` held stable through reset) the flags are `empty` = 1, `almostEmpty` = 1, `full` = 0 and `almostFull` = 0, and `rdData` = 0 (with `outDisable` low).
- R10: With the write clock more than twice as fast as the read clock, continuous writes and reads deliver every accepted word once and in order. Each pointer changes at most one Gray bit per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write clock |
| wrRstN | input | 1 | Write-domain reset, active low, asynchronous |
| rdClk | input | 1 | Read clock |
| rdRstN | input | 1 | Read-domain reset, active low, asynchronous |
| cfgMode | input | 2 | 0 pass-through, 1 widening, 2 narrowing, 3 pass-through; change only in reset |
| outDisable | input | 1 | Drive all read data high while `rdEn` is low |
| wrEn | input | 1 | Write request |
| wrData | input | 80 | Ten 8-bit lane slots; low nibble only in modes 0, 1 and 3 |
| rdEn | input | 1 | Read request |
| rdData | output | 80 | Ten 8-bit lane slots of read data |
| full | output | 1 | Eight entries held (write domain) |
| almostFull | output | 1 | Occupancy at or above the high watermark (write domain) |
| empty | output | 1 | No entries held (read domain) |
| almostEmpty | output | 1 | Occupancy at or below the low watermark (read domain) |

## Verification
Two things can land in the same cycle:

- A write attempt that meets a `full` flag about to release, because the synchronized read pointer advances on that same write edge.
- A read in narrowing mode whose second half frees an entry just as the write side refills it.

The bench provokes both by streaming from a fast write clock into a slow read clock until `full` toggles repeatedly. It also forces write attempts on top of a full FIFO and read attempts on an empty one. A scoreboard judges the result: it records only the writes the bench saw accepted, and compares every read word in order. A dropped, duplicated or misplaced nibble therefore shows up as a mismatch or as an unexpected extra word.

// File: rtl/io_ratio_pkg.sv
package io_ratio_pkg;

  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,
    MODE_WIDEN  = 2'd1,
    MODE_NARROW = 2'd2,
    MODE_ALT    = 2'd3
  } ratioMode_e;

  // Write-side strobes from control to datapath.
  typedef struct packed {
    logic stageLow;  // capture low nibbles of the first half of a pair
    logic commit;    // write one entry into storage
    logic combine;   // entry is staged low half plus current write
  } wrStrobe_t;

  // Read-side strobes from control to datapath.
  typedef struct packed {
    logic load;      // update the output register
    logic takeHigh;  // select upper nibble of the stored lane
  } rdStrobe_t;

endpackage

// File: rtl/io_ratio_ctrl.sv
module io_ratio_ctrl
  import io_ratio_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AF_GAP = 1,
  parameter int AE_GAP = 1,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic       wrClk,
  input  logic       wrRstN,
  input  logic       rdClk,
  input  logic       rdRstN,
  input  ratioMode_e mode,
  input  logic       wrEn,
  input  logic       rdEn,
  output wrStrobe_t  wrStb,
  output logic [AW-1:0] wrAddr,
  output rdStrobe_t  rdStb,
  output logic [AW-1:0] rdAddr,
  output logic       full,
  output logic       almostFull,
  output logic       empty,
  output logic       almostEmpty
);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int k = PW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  logic [PW-1:0] wrBin, wrGray, rdBin, rdGray;
  logic [PW-1:0] rdGrayMeta, rdGraySync, wrGrayMeta, wrGraySync;
  logic [PW-1:0] rdBinAtWr, wrBinAtRd, wrCount, rdCount;
  logic [PW-1:0] wrBinNext, rdBinNext;
  logic          wrHalf, rdHalf;
  logic          wrAccept, rdAccept, wrAdvance, rdAdvance;

  // ---------------- write domain ----------------
  assign wrAccept  = wrEn && !full;
  assign wrBinNext = wrBin + PW'(1);

  always_comb begin
    wrStb     = '0;
    wrAdvance = 1'b0;
    if (wrAccept) begin
      if (mode == MODE_WIDEN && !wrHalf) begin
        wrStb.stageLow = 1'b1;
      end else begin
        wrStb.commit  = 1'b1;
        wrStb.combine = (mode == MODE_WIDEN);
        wrAdvance     = 1'b1;
      end
    end
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
      wrHalf <= 1'b0;
    end else begin
      if (wrAccept && mode == MODE_WIDEN) wrHalf <= !wrHalf;
      if (wrAdvance) begin
        wrBin  <= wrBinNext;
        wrGray <= toGray(wrBinNext);
      end
    end
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      rdGrayMeta <= '0;
      rdGraySync <= '0;
    end else begin
      rdGrayMeta <= rdGray;
      rdGraySync <= rdGrayMeta;
    end
  end

  assign rdBinAtWr  = fromGray(rdGraySync);
  assign wrCount    = wrBin - rdBinAtWr;
  assign full       = (wrCount == PW'(DEPTH));
  assign almostFull = (wrCount >= PW'(DEPTH - AF_GAP));
  assign wrAddr     = wrBin[AW-1:0];

  // ---------------- read domain ----------------
  assign rdAccept  = rdEn && !empty;
  assign rdAdvance = rdAccept && (mode != MODE_NARROW || rdHalf);
  assign rdBinNext = rdBin + PW'(1);

  always_comb begin
    rdStb          = '0;
    rdStb.load     = rdAccept;
    rdStb.takeHigh = (mode == MODE_NARROW) && rdHalf;
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin  <= '0;
      rdGray <= '0;
      rdHalf <= 1'b0;
    end else begin
      if (rdAccept && mode == MODE_NARROW) rdHalf <= !rdHalf;
      if (rdAdvance) begin
        rdBin  <= rdBinNext;
        rdGray <= toGray(rdBinNext);
      end
    end
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      wrGrayMeta <= '0;
      wrGraySync <= '0;
    end else begin
      wrGrayMeta <= wrGray;
      wrGraySync <= wrGrayMeta;
    end
  end

  assign wrBinAtRd   = fromGray(wrGraySync);
  assign rdCount     = wrBinAtRd - rdBin;
  assign empty       = (rdCount == '0);
  assign almostEmpty = (rdCount <= PW'(AE_GAP));
  assign rdAddr      = rdBin[AW-1:0];

  // ---------------- assertions ----------------
  p_no_overflow_r4: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (full && wrEn) |=> ($stable(wrBin) && $stable(wrHalf)))
    else $error("write accepted while full");

  p_occupancy_bound_r4: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrCount <= PW'(DEPTH))
    else $error("write-side occupancy out of range");

  p_no_underflow_r5: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (empty && rdEn) |=> ($stable(rdBin) && $stable(rdHalf)))
    else $error("read accepted while empty");

  p_full_has_af_r6: assert property (@(posedge wrClk) disable iff (!wrRstN)
    full |-> almostFull)
    else $error("full without almostFull");

  p_empty_has_ae_r7: assert property (@(posedge rdClk) disable iff (!rdRstN)
    empty |-> almostEmpty)
    else $error("empty without almostEmpty");

  p_wr_gray_step_r10: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $countones(wrGray ^ $past(wrGray)) <= 1)
    else $error("write Gray pointer moved more than one bit");

  p_rd_gray_step_r10: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $countones(rdGray ^ $past(rdGray)) <= 1)
    else $error("read Gray pointer moved more than one bit");

endmodule

// File: rtl/io_ratio_dpath.sv
module io_ratio_dpath
  import io_ratio_pkg::*;
#(
  parameter int LANES = 10,
  parameter int NIB   = 4,
  parameter int DEPTH = 8,
  localparam int LW   = 2 * NIB,
  localparam int BW   = LANES * LW,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  ratioMode_e    mode,
  input  wrStrobe_t     wrStb,
  input  logic [AW-1:0] wrAddr,
  input  logic [BW-1:0] wrData,
  input  rdStrobe_t     rdStb,
  input  logic [AW-1:0] rdAddr,
  input  logic          rdEn,
  input  logic          outDisable,
  output logic [BW-1:0] rdData
);

  logic [LANES*NIB-1:0] stagedLow;
  logic [BW-1:0]        store [DEPTH];
  logic [BW-1:0]        wordIn, wordOut, shaped, rdQ;
  logic [LANES-1:0]     upperBusy;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [NIB-1:0] inLo, inHi, memLo, memHi, pick;

    assign inLo  = wrData[ln*LW +: NIB];
    assign inHi  = wrData[ln*LW+NIB +: NIB];
    assign memLo = wordOut[ln*LW +: NIB];
    assign memHi = wordOut[ln*LW+NIB +: NIB];
    assign pick  = rdStb.takeHigh ? memHi : memLo;

    assign wordIn[ln*LW +: LW] =
      wrStb.combine         ? {inLo, stagedLow[ln*NIB +: NIB]} :
      (mode == MODE_NARROW) ? {inHi, inLo} :
                              {{NIB{1'b0}}, inLo};

    assign shaped[ln*LW +: LW] =
      (mode == MODE_WIDEN)  ? {memHi, memLo} :
      (mode == MODE_NARROW) ? {{NIB{1'b0}}, pick} :
                              {{NIB{1'b0}}, memLo};

    assign upperBusy[ln] = |rdQ[ln*LW+NIB +: NIB];
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      stagedLow <= '0;
    end else if (wrStb.stageLow) begin
      for (int ln = 0; ln < LANES; ln++)
        stagedLow[ln*NIB +: NIB] <= wrData[ln*LW +: NIB];
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrStb.commit) store[wrAddr] <= wordIn;
  end

  assign wordOut = store[rdAddr];

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) rdQ <= '0;
    else if (rdStb.load) rdQ <= shaped;
  end

  assign rdData = (outDisable && !rdEn) ? '1 : rdQ;

  p_narrow_upper_zero_r3: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (mode != MODE_WIDEN) |-> (upperBusy == '0))
    else $error("upper nibble set in a 4-bit read mode");

endmodule

// File: rtl/io_ratio_fifo.sv
module io_ratio_fifo
  import io_ratio_pkg::*;
#(
  parameter int LANES  = 10,
  parameter int NIB    = 4,
  parameter int DEPTH  = 8,
  parameter int AF_GAP = 1,
  parameter int AE_GAP = 1,
  localparam int BW    = LANES * 2 * NIB,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic [1:0]    cfgMode,
  input  logic          outDisable,
  input  logic          wrEn,
  input  logic [BW-1:0] wrData,
  input  logic          rdEn,
  output logic [BW-1:0] rdData,
  output logic          full,
  output logic          almostFull,
  output logic          empty,
  output logic          almostEmpty
);

  ratioMode_e    modeSel;
  wrStrobe_t     wrStb;
  rdStrobe_t     rdStb;
  logic [AW-1:0] wrAddr, rdAddr;

  assign modeSel = ratioMode_e'(cfgMode);

  io_ratio_ctrl #(
    .DEPTH(DEPTH), .AF_GAP(AF_GAP), .AE_GAP(AE_GAP)
  ) u_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
    .mode(modeSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrStb(wrStb), .wrAddr(wrAddr), .rdStb(rdStb), .rdAddr(rdAddr),
    .full(full), .almostFull(almostFull),
    .empty(empty), .almostEmpty(almostEmpty)
  );

  io_ratio_dpath #(
    .LANES(LANES), .NIB(NIB), .DEPTH(DEPTH)
  ) u_dpath (
    .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
    .mode(modeSel), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .rdStb(rdStb), .rdAddr(rdAddr), .rdEn(rdEn),
    .outDisable(outDisable), .rdData(rdData)
  );

endmodule

// File: tb/tb_io_ratio_fifo.sv
module tb_io_ratio_fifo;

  localparam int WR_PERIOD   = 10;
  localparam int RD_PERIOD   = 26;
  localparam int LANES       = 10;
  localparam int LW          = 8;
  localparam int BW          = LANES * LW;
  localparam int DEPTH       = 8;
  localparam int WATCHDOG_NS = 1500000;

  logic          wrClk = 1'b0, rdClk = 1'b0;
  logic          wrRstN = 1'b0, rdRstN = 1'b0;
  logic [1:0]    cfgMode = 2'd0;
  logic          outDisable = 1'b0;
  logic          wrEn = 1'b0, rdEn = 1'b0;
  logic [BW-1:0] wrData = '0;
  logic [BW-1:0] rdData;
  logic          full, almostFull, empty, almostEmpty;

  io_ratio_fifo dut (
    .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
    .cfgMode(cfgMode), .outDisable(outDisable),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData),
    .full(full), .almostFull(almostFull),
    .empty(empty), .almostEmpty(almostEmpty)
  );

  always #(WR_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2) rdClk = ~rdClk;

  int            total = 0, bad = 0;
  logic [BW-1:0] expQ[$];
  int            wrLeft = 0, rdLeft = 0, seq = 0;
  bit            wrForce = 0, rdForce = 0;
  bit            halfPending = 0, pendCheck = 0, holdCheck = 0;
  logic [BW-1:0] pendLow = '0, lastOut = '0, curWord, expWord;
  string         curTag = "R1";

  task automatic check(input bit ok, input string tag,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] genWord(input int s);
    logic [BW-1:0] w;
    for (int i = 0; i < LANES; i++) w[i*LW +: LW] = 8'((s * 29 + i * 53 + 17) & 255);
    return w;
  endfunction

  // kind 0: low nibble only, 1: pair (a low, b high), 2: high nibble of a
  function automatic logic [BW-1:0] shapeExp(input logic [BW-1:0] a,
                                             input logic [BW-1:0] b, input int kind);
    logic [BW-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      case (kind)
        0:       r[i*LW +: LW] = {4'h0, a[i*LW +: 4]};
        1:       r[i*LW +: LW] = {b[i*LW +: 4], a[i*LW +: 4]};
        default: r[i*LW +: LW] = {4'h0, a[i*LW+4 +: 4]};
      endcase
    end
    return r;
  endfunction

  task automatic recordWrite(input logic [BW-1:0] d);
    case (cfgMode)
      2'd1: begin
        if (!halfPending) begin
          pendLow = d; halfPending = 1;
        end else begin
          expQ.push_back(shapeExp(pendLow, d, 1)); halfPending = 0;
        end
      end
      2'd2: begin
        expQ.push_back(shapeExp(d, d, 0));
        expQ.push_back(shapeExp(d, d, 2));
      end
      default: expQ.push_back(shapeExp(d, d, 0));
    endcase
  endtask

  // driver: writes at the write-clock falling edge
  always @(negedge wrClk) begin
    if (wrRstN && wrLeft > 0 && (!full || wrForce)) begin
      curWord = genWord(seq);
      seq++;
      wrEn   = 1'b1;
      wrData = curWord;
      wrLeft--;
      if (!full) recordWrite(curWord);
    end else begin
      wrEn = 1'b0;
    end
  end

  // monitor: compares the word loaded on the previous read edge
  always @(negedge rdClk) begin
    if (pendCheck) begin
      if (expQ.size() == 0) begin
        check(1'b0, {curTag, " unexpected word"}, rdData, '0);
      end else begin
        expWord = expQ.pop_front();
        check(rdData == expWord, {curTag, " data order"}, rdData, expWord);
      end
      lastOut = rdData;
    end
    if (holdCheck) check(rdData == lastOut, "R5 output held on empty read", rdData, lastOut);
    pendCheck = 0;
    holdCheck = 0;
    if (rdRstN && rdLeft > 0 && !empty) begin
      rdEn = 1'b1; pendCheck = 1; rdLeft--;
    end else if (rdRstN && rdForce && empty) begin
      rdEn = 1'b1; holdCheck = 1;
    end else begin
      rdEn = 1'b0;
    end
  end

  task automatic waitWr(input int n);
    repeat (n) begin @(negedge wrClk); #1; end
  endtask

  task automatic waitRd(input int n);
    repeat (n) begin @(negedge rdClk); #1; end
  endtask

  task automatic writeEntries(input int n);
    wrLeft = (cfgMode == 2'd1) ? 2 * n : n;
    while (wrLeft > 0) waitWr(1);
    waitWr(2);
  endtask

  task automatic readUntilDone(input int n);
    rdLeft = n;
    while (rdLeft > 0 || pendCheck) waitRd(1);
  endtask

  task automatic drain();
    rdLeft = 1000000;
    while (expQ.size() != 0 || pendCheck) waitRd(1);
    rdLeft = 0;
    waitRd(1);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic resetAll(input logic [1:0] m);
    wrLeft = 0; rdLeft = 0; wrForce = 0; rdForce = 0;
    waitRd(2);
    wrRstN = 1'b0; rdRstN = 1'b0;
    cfgMode = m;
    expQ.delete();
    halfPending = 0; pendCheck = 0; holdCheck = 0; lastOut = '0;
    waitRd(4);
    wrRstN = 1'b1; rdRstN = 1'b1;
    waitRd(3);
  endtask

  initial begin
    #(WATCHDOG_NS);
    total++; bad++;
    $display("FAIL R10 watchdog expired actual=%0d expected=0", expQ.size());
    summary();
    $finish;
  end

  initial begin
    for (int m = 0; m < 3; m++) begin
      resetAll(2'(m));
      curTag = (m == 0) ? "R1" : (m == 1) ? "R2" : "R3";

      // R9 reset state
      check(empty == 1'b1,       "R9 empty after reset",       BW'(empty), BW'(1));
      check(almostEmpty == 1'b1, "R9 almostEmpty after reset", BW'(almostEmpty), BW'(1));
      check(full == 1'b0,        "R9 full after reset",        BW'(full), BW'(0));
      check(almostFull == 1'b0,  "R9 almostFull after reset",  BW'(almostFull), BW'(0));
      check(rdData == '0,        "R9 rdData after reset",      rdData, '0);

      // R6 / R4 watermark and full
      writeEntries(DEPTH - 1);
      check(almostFull == 1'b1, "R6 almostFull at 7 entries", BW'(almostFull), BW'(1));
      check(full == 1'b0,       "R4 full low at 7 entries",   BW'(full), BW'(0));
      writeEntries(1);
      check(full == 1'b1,       "R4 full at 8 entries",       BW'(full), BW'(1));
      check(almostFull == 1'b1, "R6 almostFull while full",   BW'(almostFull), BW'(1));
      wrForce = 1; wrLeft = 3;
      while (wrLeft > 0) waitWr(1);
      wrForce = 0; waitWr(2);
      check(full == 1'b1, "R4 full after dropped writes", BW'(full), BW'(1));
      waitRd(6);
      check(empty == 1'b0,       "R7 empty low when full",       BW'(empty), BW'(0));
      check(almostEmpty == 1'b0, "R7 almostEmpty low when full", BW'(almostEmpty), BW'(0));
      drain();   // R4: a dropped write would surface as an unexpected word
      waitRd(6);
      check(empty == 1'b1,       "R7 empty after drain",       BW'(empty), BW'(1));
      check(almostEmpty == 1'b1, "R7 almostEmpty after drain", BW'(almostEmpty), BW'(1));
      waitWr(6);
      check(full == 1'b0,       "R4 full cleared after drain",       BW'(full), BW'(0));
      check(almostFull == 1'b0, "R6 almostFull cleared after drain", BW'(almostFull), BW'(0));

      // R7 almost-empty falls and rises without empty
      writeEntries(1); waitRd(6);
      check(empty == 1'b0,       "R7 one entry not empty",  BW'(empty), BW'(0));
      check(almostEmpty == 1'b1, "R7 one entry almost empty", BW'(almostEmpty), BW'(1));
      writeEntries(1); waitRd(6);
      check(almostEmpty == 1'b0, "R7 two entries not almost empty", BW'(almostEmpty), BW'(0));
      readUntilDone((m == 2) ? 2 : 1);
      waitRd(4);
      check(almostEmpty == 1'b1, "R7 almostEmpty back without empty", BW'(almostEmpty), BW'(1));
      check(empty == 1'b0,       "R7 empty stays low",                BW'(empty), BW'(0));
      drain();

      // R5 read while empty
      waitRd(6);
      rdForce = 1; waitRd(3); rdForce = 0; waitRd(2);
      curTag = "R5";
      writeEntries(2);
      drain();

      // R10 streaming with a fast write clock
      curTag = "R10";
      rdLeft = 1000000;
      writeEntries(40);
      drain();
    end

    // R8 output disable
    resetAll(2'd0);
    curTag = "R8";
    writeEntries(1);
    drain();
    outDisable = 1'b1; waitRd(1);
    check(rdData == '1, "R8 forced high while idle", rdData, '1);
    outDisable = 1'b0; waitRd(1);
    check(rdData == lastOut, "R8 last word when not disabled", rdData, lastOut);
    outDisable = 1'b1;
    writeEntries(4);
    drain();
    waitRd(1);
    check(rdData == '1, "R8 forced high after reads", rdData, '1);
    outDisable = 1'b0;

    summary();
    $finish;
  end

endmodule